// File: doc/BRIEF.md
# Framed Serial Result Read Transmitter

This block is the read controller on the converter side of a serial result link. A falling edge on an active-low read strobe starts a read cycle, if chip select is low and the converter reports that it is waiting or sampling. The stored result word is then sent MSB first as a serial bit stream, with a frame-sync strobe that marks each frame period. A shared output enable tells the pad logic whether the sync and data lines are driven or left at high impedance. A busy flag marks the whole read.

All timing is counted in serial clock cycles from the start edge, which is cycle 0. Sync pulses high for one cycle at the start of every period. The period is the full word width in word mode and half of it in byte mode. Data lags sync by two cycles in both modes, so in byte mode a single read covers two sync periods, and the second sync pulse falls just before the low byte begins.

Top module: `serial_result_reader`

## Requirements
- R1: A read starts at the clock edge where the read strobe, high on the previous edge, is sampled low while chip select is low, the phase flag is high and no read is running. Starting from the next cycle (cycle 0), busy and output enable are high. A strobe held low, with no new falling edge, never starts a read.
- R2: In word mode (mode input 0), sync is high in cycles 0 and 16 of the read and low in every other cycle.
- R3: In byte mode (mode input 1), sync is high in cycles 0, 8 and 16 of the read and low in every other cycle.
- R4: The data output is 0 in cycles 0 and 1. Result bit 15 appears in cycle 2 and the following bits come one per cycle, so bit 0 appears in cycle 17.
- R5: After bit 0 has been held for one cycle, from cycle 18 on, busy and output enable are low. While output enable is low, sync and data read 0.
- R6: Chip select going high during a read drops output enable in the same cycle. Busy falls at the next clock edge, and output enable stays low until a new read starts, even if chip select returns low.
- R7: A read strobe falling edge during a running read has no effect on that frame.
- R8: A read strobe falling edge while the phase flag is low, or while chip select is high, starts nothing.
- R9: The result word is captured at the start edge. Changing the result input during the read does not alter the bits sent.
- R10: The mode input is captured at the start edge. Changing it during the read does not alter the sync pattern of that frame.
- R11: During reset, busy, output enable, sync and data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_ni | input | 1 | Active-low read strobe; falling edge requests a read |
| cs_ni | input | 1 | Active-low chip select |
| byte_mode_i | input | 1 | 0 = word-period sync, 1 = half-word-period sync |
| phase_ok_i | input | 1 | High while the converter is waiting or sampling |
| result_i | input | DATA_W | Conversion result to send |
| sdo_o | output | 1 | Serial data bit, MSB first |
| sync_o | output | 1 | Frame sync strobe |
| oe_o | output | 1 | Shared drive enable for sync and data (0 = high impedance) |
| busy_o | output | 1 | High for the duration of a read |

## Verification
The assertions assume that the strobe, select, mode and phase inputs change only between clock edges and are never X after reset. They also assume that chip select is the only thing that ends a read early. The bench drives every input on the falling clock edge and samples on the falling edge too, so every input is stable at each rising edge. Random frames disturb the strobe, mode and result inputs only while a read is running, to exercise the capture and ignore rules. Aborts, the strobe held low, a low phase flag and a start with chip select high are covered by directed cases.

// File: rtl/serial_result_reader_pkg.sv
package serial_result_reader_pkg;

   typedef enum logic {
      MODE_WORD = 1'b0,
      MODE_BYTE = 1'b1
   } sync_mode_e;

   parameter int unsigned LEAD_CYCLES_DEFAULT = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/srr_start_gate.sv
module srr_start_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rd_ni,
   input  logic cs_ni,
   input  logic phase_ok_i,
   input  logic busy_i,
   output logic start_o
);

   logic rd_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_prev_q <= 1'b1;
      else         rd_prev_q <= rd_ni;
   end

   assign start_o = rd_prev_q && !rd_ni && !cs_ni && phase_ok_i && !busy_i;

endmodule

// File: rtl/srr_frame_seq.sv
module srr_frame_seq
   import serial_result_reader_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LEAD_CYCLES = LEAD_CYCLES_DEFAULT,
   parameter int unsigned SYNC_HIGH   = 1,
   localparam int unsigned FRAME_LEN  = DATA_W + LEAD_CYCLES,
   localparam int unsigned CNT_W      = $clog2(FRAME_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic             mode_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             sync_raw_o,
   output logic             shift_en_o,
   output logic             window_o
);

   localparam logic [CNT_W-1:0] LAST      = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] LEAD      = CNT_W'(LEAD_CYCLES);
   localparam logic [CNT_W-1:0] MASK_WORD = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] MASK_BYTE = CNT_W'(DATA_W / 2 - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   sync_mode_e       mode_q;
   logic [CNT_W-1:0] slot;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         mode_q <= MODE_WORD;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         mode_q <= sync_mode_e'(mode_i);
      end else if (busy_q) begin
         if (abort_i || cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign slot = cnt_q & ((mode_q == MODE_BYTE) ? MASK_BYTE : MASK_WORD);

   generate
      if (SYNC_HIGH == 1) begin : g_sync_pulse
         assign sync_raw_o = busy_q && (slot == '0);
      end else begin : g_sync_wide
         assign sync_raw_o = busy_q && (slot < CNT_W'(SYNC_HIGH));
      end
   endgenerate

   assign busy_o     = busy_q;
   assign cnt_o      = cnt_q;
   assign window_o   = busy_q && (cnt_q >= LEAD);
   assign shift_en_o = busy_q && (cnt_q >= LEAD) && (cnt_q != LAST);

   p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o && cnt_o == '0);

   p_frame_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && cnt_o == LAST && !start_i |=> !busy_o);

   p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && abort_i && !start_i |=> !busy_o);

   p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !abort_i && cnt_o != LAST |=> busy_o && cnt_o == $past(cnt_o) + 1'b1);

   p_mode_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !start_i |=> $stable(mode_q));

endmodule

// File: rtl/srr_shifter.sv
module srr_shifter #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              msb_o
);

   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (load_i)  sh_q <= word_i;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
   end

   assign msb_o = sh_q[DATA_W-1];

   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i && !shift_i |=> $stable(sh_q));

   p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> sh_q == $past(word_i));

endmodule

// File: rtl/serial_result_reader.sv
module serial_result_reader
   import serial_result_reader_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LEAD_CYCLES = LEAD_CYCLES_DEFAULT,
   parameter int unsigned SYNC_HIGH   = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_ni,
   input  logic              cs_ni,
   input  logic              byte_mode_i,
   input  logic              phase_ok_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              sdo_o,
   output logic              sync_o,
   output logic              oe_o,
   output logic              busy_o
);

   localparam int unsigned FRAME_LEN = DATA_W + LEAD_CYCLES;
   localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

   generate
      if (DATA_W < 4 || !is_pow2(DATA_W)) begin : g_bad_width
         $error("DATA_W must be a power of two, at least 4");
      end
      if (LEAD_CYCLES < 1) begin : g_bad_lead
         $error("LEAD_CYCLES must be at least 1");
      end
      if (SYNC_HIGH < 1 || SYNC_HIGH >= DATA_W / 2) begin : g_bad_sync
         $error("SYNC_HIGH must lie in 1 .. DATA_W/2-1");
      end
   endgenerate

   logic             start;
   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             sync_raw;
   logic             shift_en;
   logic             window;
   logic             msb;

   srr_start_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_ni      (rd_ni),
      .cs_ni      (cs_ni),
      .phase_ok_i (phase_ok_i),
      .busy_i     (busy),
      .start_o    (start)
   );

   srr_frame_seq #(
      .DATA_W      (DATA_W),
      .LEAD_CYCLES (LEAD_CYCLES),
      .SYNC_HIGH   (SYNC_HIGH)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .abort_i    (cs_ni),
      .mode_i     (byte_mode_i),
      .busy_o     (busy),
      .cnt_o      (cnt),
      .sync_raw_o (sync_raw),
      .shift_en_o (shift_en),
      .window_o   (window)
   );

   srr_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (start),
      .shift_i (shift_en),
      .word_i  (result_i),
      .msb_o   (msb)
   );

   assign oe_o   = busy && !cs_ni;
   assign sync_o = oe_o && sync_raw;
   assign sdo_o  = oe_o && window && msb;
   assign busy_o = busy;

   p_start_drives_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |=> oe_o || cs_ni);

   p_quiet_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !oe_o && !sync_o && !sdo_o);

   p_gate_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && (!phase_ok_i || cs_ni) |=> !busy_o);

endmodule

// File: tb/serial_result_reader_tb_top.sv
`timescale 1ns/1ps
module serial_result_reader_tb_top;

   localparam int DW = 16;
   localparam int FL = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1;
   logic          cs_n = 1'b1;
   logic          bmode = 1'b0;
   logic          phase = 1'b1;
   logic [DW-1:0] result = '0;
   logic          sdo, sync, oe, busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   serial_result_reader dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .rd_ni       (rd_n),
      .cs_ni       (cs_n),
      .byte_mode_i (bmode),
      .phase_ok_i  (phase),
      .result_i    (result),
      .sdo_o       (sdo),
      .sync_o      (sync),
      .oe_o        (oe),
      .busy_o      (busy)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic exp_sync(input int k, input bit bm);
      return (k < FL) && ((k % (bm ? DW/2 : DW)) == 0);
   endfunction

   function automatic logic exp_sdo(input int k, input logic [DW-1:0] w);
      return (k >= 2 && k <= FL-1) ? w[FL-1-k] : 1'b0;
   endfunction

   task automatic check_idle(input string req);
      chk(req, "busy", busy, 1'b0);
      chk(req, "oe", oe, 1'b0);
      chk(req, "sync", sync, 1'b0);
      chk(req, "sdo", sdo, 1'b0);
   endtask

   // Full frame; caller sits just after a negedge. pk/rk/bk < 0 disable a disturbance.
   task automatic run_frame(input logic [DW-1:0] w, input bit bm, input int pk, input int rk, input int bk);
      rd_n = 1'b1; cs_n = 1'b0; phase = 1'b1;
      @(negedge clk);
      result = w; bmode = bm; rd_n = 1'b0;
      for (int k = 0; k <= FL; k++) begin
         @(negedge clk);
         chk("R1", "busy", busy, k < FL);
         chk("R5", "oe", oe, k < FL);
         chk(bm ? "R3" : "R2", "sync", sync, exp_sync(k, bm));
         chk("R4", "sdo", sdo, exp_sdo(k, w));
         if (k == pk) result = DW'($urandom);          // R9
         if (k == rk) rd_n = 1'b1;                      // R7
         if (rk >= 0 && k == rk + 1) rd_n = 1'b0;
         if (k == bk) bmode = ~bmode;                   // R10
      end
      if (rd_n == 1'b0) begin
         @(negedge clk);
         chk("R1", "held strobe busy", busy, 1'b0);
      end
      rd_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check_idle("R11");
      rst_n = 1'b1;
      @(negedge clk);

      // directed word and byte frames with edge patterns
      run_frame(16'h8001, 1'b0, -1, -1, -1);
      run_frame(16'hFFFF, 1'b1, -1, -1, -1);
      run_frame(16'h0000, 1'b0, -1, -1, -1);
      run_frame(16'hA5C3, 1'b1, 3, 6, 4);

      // R8: phase low blocks the start
      @(negedge clk); phase = 1'b0; cs_n = 1'b0;
      @(negedge clk); rd_n = 1'b0;
      repeat (3) begin @(negedge clk); check_idle("R8"); end
      rd_n = 1'b1; phase = 1'b1;

      // R8: chip select high blocks the start
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk); rd_n = 1'b0;
      repeat (3) begin @(negedge clk); check_idle("R8"); end
      rd_n = 1'b1; cs_n = 1'b0;

      // R6: abort by chip select
      @(negedge clk); result = 16'h1234; bmode = 1'b0; rd_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6", "busy before abort", busy, 1'b1);
      cs_n = 1'b1;
      #1;
      chk("R6", "oe same cycle", oe, 1'b0);
      chk("R6", "sdo", sdo, 1'b0);
      chk("R6", "sync", sync, 1'b0);
      @(negedge clk);
      chk("R6", "busy after abort", busy, 1'b0);
      cs_n = 1'b0;
      repeat (3) begin @(negedge clk); check_idle("R6"); end
      rd_n = 1'b1;
      @(negedge clk);

      // random frames
      for (int i = 0; i < 40; i++) begin
         logic [DW-1:0] w;
         bit bm;
         int pk, rk, bk;
         w  = DW'($urandom);
         bm = 1'($urandom);
         pk = int'($urandom % 20) - 2;
         rk = int'($urandom % 20) - 4;
         if (rk > 15) rk = -1;
         bk = int'($urandom % 18);
         run_frame(w, bm, pk, rk, bk);
         repeat (int'($urandom % 3)) @(negedge clk);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule